// File: doc/BRIEF.md
# Infrared Serial UART with Pulse Shaping

This block is a byte-wide serial port for slow infrared links. Each character travels as a ten-bit frame: one start bit, eight data bits with the least significant bit first, and one stop bit. A zero bit is sent as a short light pulse at the start of its bit cell, and a one bit is sent as darkness. The receiver regenerates bytes from incoming pulses. It also times every pulse it sees and raises a sticky error flag when a pulse is too narrow or too wide.

Software reaches the block through a small register port. It holds a control register, a status word, an interrupt mask, a transmit holding register, a receive data register, an infrared control register and an infrared status register. All bit timing comes from an external enable, `tick16`, which pulses once per sixteenth of a bit cell. The single interrupt line is high whenever a status bit is set and its mask bit is set. Frame wrapping, escape coding and checksums belong to the software above this block.

Top module: `sir_uart`

Register addresses: 0 control, 1 status, 2 interrupt mask, 3 transmit data (write), 4 receive data (read), 5 infrared control, 6 infrared status.

## Requirements
- R1: After reset, status reads 0x03 (transmit buffer empty and shift register empty). Infrared status reads 0, `irq` is low and `ir_tx` is low.
- R2: Control bit 0 enables the transmitter. While it is 0, a byte written to address 3 stays in the holding register: status bit 0 stays 0 and no pulse appears on `ir_tx`.
- R3: A bit cell lasts 16 ticks. The frame is a start bit of 0, then data bits from the least significant bit up, then a stop bit of 1. A 0 bit drives `ir_tx` high for the first 3 ticks of its cell, and a 1 bit drives no pulse.
- R4: When infrared control bit 1 is set, each pulse lasts 1 tick instead of 3.
- R5: Status bit 0 (transmit buffer empty) sets when the holding register moves into the shifter. Status bit 1 (shift register empty) is 0 while a frame is being sent.
- R6: Writing control with bit 2 set discards the byte in the holding register, so status bit 0 returns to 1 and that byte is never sent.
- R7: A received frame puts its eight data bits into the receive data register and sets status bit 2 (receive buffer full).
- R8: A pulse inside the stop-bit cell sets status bit 4 (framing error). The byte is still stored. Status bit 3 (parity error) always reads 0 because the frame carries no parity.
- R9: If a frame completes while status bit 2 is still set, status bit 5 (overrun) sets and the stored byte is kept. Status bit 6 is the OR of bits 3, 4 and 5.
- R10: Reading address 4 clears status bits 2 to 6.
- R11: A received pulse that spans fewer than 1 tick or more than 8 ticks sets infrared status bit 0. Writing 1 to infrared control bit 0 clears it.
- R12: `irq` is the OR of the status bits at positions 0, 1, 2 and 6, each ANDed with the mask bit at the same position. The other mask bits are not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One pulse per sixteenth of a bit cell |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 4 has side effects |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| ir_rx | input | 1 | Infrared receive line, high while light is detected |
| ir_tx | output | 1 | Infrared transmit line, high while the emitter is lit |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit, 8 data bits, 3-tick and 1-tick pulse widths, and an accepted pulse range of 1 to 8 ticks. It raises `tick16` every fourth clock, so a 3-tick pulse is exactly 12 clocks long and pulse lengths can be counted in clocks. Feeding the transmitter back into the receiver lets a sweep of 128 distinct bytes check each byte's pulse count, each pulse's width and the decoded value. Driving the receive line directly from the bench produces a stop-bit pulse, a one-clock glitch and a ten-tick pulse, which the loopback path never produces.

// File: rtl/sir_uart_pkg.sv
package sir_uart_pkg;

  localparam logic [2:0] ADR_CTRL   = 3'd0;
  localparam logic [2:0] ADR_STAT   = 3'd1;
  localparam logic [2:0] ADR_MASK   = 3'd2;
  localparam logic [2:0] ADR_TXD    = 3'd3;
  localparam logic [2:0] ADR_RXD    = 3'd4;
  localparam logic [2:0] ADR_IRCTL  = 3'd5;
  localparam logic [2:0] ADR_IRSTAT = 3'd6;

  // status / mask bit positions (mask shares the status layout)
  localparam int ST_TBE  = 0;
  localparam int ST_TSBE = 1;
  localparam int ST_RBF  = 2;
  localparam int ST_PAR  = 3;
  localparam int ST_FRM  = 4;
  localparam int ST_OVR  = 5;
  localparam int ST_SUM  = 6;

  // pulse length in ticks for the selected width option
  function automatic int pulse_ticks(input logic narrow, input int wide_t, input int short_t);
    return narrow ? short_t : wide_t;
  endfunction

  // acceptance window for a received pulse
  function automatic logic pulse_ok(input int width, input int lo, input int hi);
    return (width >= lo) && (width <= hi);
  endfunction

endpackage

// File: rtl/sir_tx.sv
module sir_tx #(
  parameter int OVS          = 16,
  parameter int DATA_W       = 8,
  parameter int NORMAL_TICKS = 3,
  parameter int NARROW_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              narrow,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  output logic              tbe,
  output logic              tsbe,
  output logic              ir_tx
);
  import sir_uart_pkg::*;

  localparam int FRAME_BITS = DATA_W + 2;
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(FRAME_BITS);

  logic [DATA_W-1:0]     hold_q;
  logic                  hold_full_q;
  logic [FRAME_BITS-1:0] frame_q;
  logic [BW-1:0]         bit_q;
  logic [CW-1:0]         cnt_q;
  logic                  busy_q;
  logic                  cell_end;
  logic                  frame_end;
  logic                  start_evt;
  logic [CW-1:0]         width;

  assign cell_end  = busy_q && tick && (cnt_q == CW'(OVS - 1));
  assign frame_end = cell_end && (bit_q == BW'(FRAME_BITS - 1));
  assign start_evt = tick && en && hold_full_q && (!busy_q || frame_end);
  assign width     = CW'(pulse_ticks(narrow, NORMAL_TICKS, NARROW_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      bit_q   <= '0;
      frame_q <= '1;
    end else if (start_evt) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      bit_q   <= '0;
      frame_q <= {1'b1, hold_q, 1'b0};
    end else if (frame_end) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
    end else if (cell_end) begin
      cnt_q <= '0;
      bit_q <= bit_q + 1'b1;
    end else if (busy_q && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full_q <= 1'b0;
      hold_q      <= '0;
    end else if (wr) begin
      hold_full_q <= 1'b1;
      hold_q      <= wdata;
    end else if (clr || start_evt) begin
      hold_full_q <= 1'b0;
    end
  end

  assign tbe   = !hold_full_q;
  assign tsbe  = !busy_q;
  assign ir_tx = busy_q && !frame_q[bit_q] && (cnt_q < width);

  // checker: ticks spent lit in one pulse
  logic [CW:0] lit_ticks_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               lit_ticks_q <= '0;
    else if (!ir_tx)          lit_ticks_q <= '0;
    else if (tick)            lit_ticks_q <= lit_ticks_q + 1'b1;
  end

  AST_TX_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lit_ticks_q) <= NORMAL_TICKS); // R3
  AST_TX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tsbe) |-> $past(en)); // R2
  AST_TX_DARK_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tsbe |-> !ir_tx); // R5

endmodule

// File: rtl/sir_pwchk.sv
module sir_pwchk #(
  parameter int SYNC   = 2,
  parameter int PW_MIN = 1,
  parameter int PW_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  input  logic rx_in,
  output logic rise,
  output logic pw_err_evt
);
  import sir_uart_pkg::*;

  localparam int WW = $clog2(PW_MAX + 2);

  logic [SYNC-1:0] sync_q;
  logic            lvl_d_q;
  logic            lvl;
  logic            fall;
  logic [WW-1:0]   wid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      lvl_d_q <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC-2:0], rx_in};
      lvl_d_q <= lvl;
    end
  end

  assign lvl  = sync_q[SYNC-1];
  assign rise = lvl && !lvl_d_q;
  assign fall = !lvl && lvl_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wid_q <= '0;
    else if (rise)
      wid_q <= tick ? WW'(1) : '0;
    else if (lvl && tick && (int'(wid_q) <= PW_MAX))
      wid_q <= wid_q + 1'b1;
  end

  assign pw_err_evt = en && fall && !pulse_ok(int'(wid_q), PW_MIN, PW_MAX);

  AST_PW_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wid_q) <= PW_MAX + 1); // R11

endmodule

// File: rtl/sir_rx.sv
module sir_rx #(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en,
  input  logic              rise,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              ferr
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(FRAME_BITS);
  localparam int HALF = OVS / 2;

  logic              active_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic              seen_q;
  logic              seen_now;
  logic              cell_end;
  logic [DATA_W-1:0] shreg_q;

  assign seen_now = seen_q || rise;
  assign cell_end = active_q && tick && (cnt_q == CW'(OVS - 1));
  assign done     = cell_end && (bit_q == BW'(FRAME_BITS - 1));
  assign data     = shreg_q;
  assign ferr     = seen_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= '0;
      seen_q   <= 1'b0;
      shreg_q  <= '0;
    end else if (!en) begin
      active_q <= 1'b0;
    end else if (!active_q) begin
      if (rise) begin
        // cells are centred on the expected pulse edges
        active_q <= 1'b1;
        cnt_q    <= CW'(HALF);
        bit_q    <= '0;
        seen_q   <= 1'b0;
      end
    end else if (cell_end) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      if (done) begin
        active_q <= 1'b0;
      end else begin
        if (bit_q != '0) shreg_q <= {!seen_now, shreg_q[DATA_W-1:1]};
        bit_q <= bit_q + 1'b1;
      end
    end else begin
      seen_q <= seen_now;
      if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_RX_DONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active_q); // R7

endmodule

// File: rtl/sir_uart.sv
module sir_uart #(
  parameter int OVS          = 16,
  parameter int DATA_W       = 8,
  parameter int NORMAL_TICKS = 3,
  parameter int NARROW_TICKS = 1,
  parameter int PW_MIN       = 1,
  parameter int PW_MAX       = 8,
  parameter int SYNC         = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ir_rx,
  output logic              ir_tx,
  output logic              irq
);
  import sir_uart_pkg::*;

  localparam logic [6:0] MASK_KEEP = 7'b100_0111;

  logic              tx_en_q, rx_en_q, narrow_q, irerr_q;
  logic [6:0]        mask_q;
  logic [DATA_W-1:0] rx_buf_q;
  logic              rbf_q, frm_q, ovr_q;
  logic              tbe, tsbe;
  logic              rise, pw_err_evt;
  logic              rx_done, rx_ferr;
  logic [DATA_W-1:0] rx_data;
  logic [6:0]        stat;
  logic              wr_ctrl, wr_txd, wr_irctl, wr_mask, rd_rxd;

  assign wr_ctrl  = reg_wr && (reg_addr == ADR_CTRL);
  assign wr_txd   = reg_wr && (reg_addr == ADR_TXD);
  assign wr_irctl = reg_wr && (reg_addr == ADR_IRCTL);
  assign wr_mask  = reg_wr && (reg_addr == ADR_MASK);
  assign rd_rxd   = reg_rd && (reg_addr == ADR_RXD);

  sir_tx #(.OVS(OVS), .DATA_W(DATA_W), .NORMAL_TICKS(NORMAL_TICKS),
           .NARROW_TICKS(NARROW_TICKS)) tx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .en(tx_en_q), .narrow(narrow_q),
    .wr(wr_txd), .wdata(reg_wdata), .clr(wr_ctrl && reg_wdata[2]),
    .tbe(tbe), .tsbe(tsbe), .ir_tx(ir_tx));

  sir_pwchk #(.SYNC(SYNC), .PW_MIN(PW_MIN), .PW_MAX(PW_MAX)) pw_i (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .en(rx_en_q), .rx_in(ir_rx),
    .rise(rise), .pw_err_evt(pw_err_evt));

  sir_rx #(.OVS(OVS), .DATA_W(DATA_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .en(rx_en_q), .rise(rise),
    .done(rx_done), .data(rx_data), .ferr(rx_ferr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      narrow_q <= 1'b0;
      mask_q   <= '0;
      irerr_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        tx_en_q <= reg_wdata[0];
        rx_en_q <= reg_wdata[1];
      end
      if (wr_mask)  mask_q   <= reg_wdata[6:0] & MASK_KEEP;
      if (wr_irctl) narrow_q <= reg_wdata[1];
      if (pw_err_evt)                    irerr_q <= 1'b1;
      else if (wr_irctl && reg_wdata[0]) irerr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf_q <= '0;
      rbf_q    <= 1'b0;
      frm_q    <= 1'b0;
      ovr_q    <= 1'b0;
    end else if (rx_done && (!rbf_q || rd_rxd)) begin
      rx_buf_q <= rx_data;
      rbf_q    <= 1'b1;
      frm_q    <= rx_ferr;
      ovr_q    <= 1'b0;
    end else begin
      if (rd_rxd) begin
        rbf_q <= 1'b0;
        frm_q <= 1'b0;
        ovr_q <= 1'b0;
      end
      if (rx_done) ovr_q <= 1'b1;
    end
  end

  always_comb begin
    stat          = '0;
    stat[ST_TBE]  = tbe;
    stat[ST_TSBE] = tsbe;
    stat[ST_RBF]  = rbf_q;
    stat[ST_PAR]  = 1'b0;
    stat[ST_FRM]  = frm_q;
    stat[ST_OVR]  = ovr_q;
    stat[ST_SUM]  = frm_q || ovr_q;
  end

  assign irq = |(stat & mask_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CTRL:   reg_rdata[1:0] = {rx_en_q, tx_en_q};
      ADR_STAT:   reg_rdata[6:0] = stat;
      ADR_MASK:   reg_rdata[6:0] = mask_q;
      ADR_RXD:    reg_rdata      = rx_buf_q;
      ADR_IRCTL:  reg_rdata[1]   = narrow_q;
      ADR_IRSTAT: reg_rdata[0]   = irerr_q;
      default:    reg_rdata      = '0;
    endcase
  end

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rxd && !rx_done |=> !rbf_q && !ovr_q && !frm_q); // R10
  AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rbf_q && !rd_rxd |=> ovr_q && $stable(rx_buf_q)); // R9
  AST_RX_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rbf_q |=> rbf_q); // R7
  AST_PW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pw_err_evt |=> irerr_q); // R11
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R12

endmodule

// File: tb/sir_uart_tb_top.sv
module sir_uart_tb_top;
  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ir_tx, irq, ir_rx;
  logic       loop_sel = 1'b0;
  logic       drv_rx = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int div = 0;

  always #4 clk = ~clk;

  assign ir_rx = loop_sel ? ir_tx : drv_rx;

  sir_uart dut_i (
    .clk(clk), .rst_n(rst_n), .tick16(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ir_rx(ir_rx), .ir_tx(ir_tx), .irq(irq));

  always @(negedge clk) begin
    div  <= (div == TDIV - 1) ? 0 : div + 1;
    tick <= (div == TDIV - 1);
  end

  // pulse monitor on ir_tx
  int npulse = 0, badw = 0, curw = 0, expw = 3 * TDIV;
  logic prev_tx = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ir_tx && !prev_tx) begin npulse = npulse + 1; curw = 1; end
    else if (ir_tx) curw = curw + 1;
    else if (prev_tx && curw != expw) badw = badw + 1;
    prev_tx = ir_tx;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    while (cyc < 190000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic chk(input int act, input int exp, input string req);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
  endtask

  task automatic pulse_rx(input int nticks);
    wait_ticks(1);
    @(negedge clk); drv_rx = 1'b1;
    wait_ticks(nticks);
    @(negedge clk); drv_rx = 1'b0;
  endtask

  task automatic drive_frame(input logic [7:0] b, input logic stop_pulse);
    logic [9:0] f;
    f = {!stop_pulse, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      if (!f[k]) begin pulse_rx(3); wait_ticks(12); end
      else wait_ticks(16);
    end
  endtask

  function automatic int zero_pulses(input logic [7:0] b);
    return 1 + 8 - $countones(b);
  endfunction

  task automatic wait_rbf(output logic ok);
    logic [7:0] s;
    ok = 1'b0;
    for (int i = 0; i < 600 && !ok; i++) begin
      rd(3'd1, s);
      ok = s[2];
    end
  endtask

  initial begin
    logic [7:0] v;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd1, v); chk(v, 8'h03, "R1 status");
    rd(3'd6, v); chk(v, 8'h00, "R1 ir status");
    chk(irq, 0, "R1 irq");
    chk(ir_tx, 0, "R1 ir_tx");

    // R2 transmitter disabled holds the byte
    npulse = 0;
    wr(3'd3, 8'h55);
    wait_ticks(40);
    rd(3'd1, v); chk(v, 8'h02, "R2 status held");
    chk(npulse, 0, "R2 no pulses");

    // R3/R5 enable: byte moves to shifter and is sent
    wr(3'd0, 8'h01);
    wait_ticks(3);
    rd(3'd1, v); chk(v & 8'h03, 8'h01, "R5 tbe set tsbe clear");
    wait_ticks(170);
    rd(3'd1, v); chk(v, 8'h03, "R5 idle after frame");
    chk(npulse, zero_pulses(8'h55), "R3 pulse count 0x55");
    chk(badw, 0, "R3 pulse width");

    // R4 narrow pulses
    wr(3'd5, 8'h02);
    expw = TDIV; npulse = 0; badw = 0;
    wr(3'd3, 8'h00);
    wait_ticks(175);
    chk(npulse, 9, "R4 pulse count");
    chk(badw, 0, "R4 narrow width");
    wr(3'd5, 8'h00);
    expw = 3 * TDIV;

    // R6 clear discards the held byte
    wr(3'd0, 8'h00);
    npulse = 0;
    wr(3'd3, 8'hA5);
    rd(3'd1, v); chk(v & 8'h01, 0, "R6 buffer loaded");
    wr(3'd0, 8'h04);
    rd(3'd1, v); chk(v, 8'h03, "R6 buffer cleared");
    wr(3'd0, 8'h01);
    wait_ticks(200);
    chk(npulse, 0, "R6 nothing sent");

    // R7/R3/R10 loopback sweep
    loop_sel = 1'b1;
    wr(3'd0, 8'h03);
    for (int i = 0; i < 128; i++) begin
      logic [7:0] b;
      b = 8'((i * 37 + 5) & 255);
      npulse = 0; badw = 0;
      wr(3'd3, b);
      wait_rbf(ok);
      chk(ok, 1, "R7 receive full");
      rd(3'd4, v); chk(v, b, "R7 loopback data");
      chk(npulse, zero_pulses(b), "R3 sweep pulse count");
      chk(badw, 0, "R3 sweep width");
      rd(3'd1, v); chk(v & 8'h7C, 0, "R10 cleared on read");
      wait_ticks(12);
    end

    // R12 interrupt masking
    wr(3'd2, 8'h04);
    wr(3'd3, 8'h81);
    wait_rbf(ok);
    chk(irq, 1, "R12 irq on receive full");
    rd(3'd4, v);
    @(negedge clk); chk(irq, 0, "R12 irq after read");
    wait_ticks(20);
    wr(3'd2, 8'h01);
    @(negedge clk); chk(irq, 1, "R12 irq on tbe");
    wr(3'd2, 8'hB8);
    rd(3'd2, v); chk(v, 8'h00, "R12 unkept mask bits");
    chk(irq, 0, "R12 no irq");
    wr(3'd2, 8'h00);

    // R9 overrun keeps the first byte
    wr(3'd3, 8'h3C);
    wait_ticks(2);
    wr(3'd3, 8'hC3);
    wait_ticks(340);
    rd(3'd1, v); chk(v, 8'h67, "R9 overrun status");
    rd(3'd4, v); chk(v, 8'h3C, "R9 first byte kept");
    rd(3'd1, v); chk(v, 8'h03, "R10 status after read");

    // R8 framing error from a pulse in the stop cell
    loop_sel = 1'b0;
    wr(3'd0, 8'h02);
    drive_frame(8'h5A, 1'b1);
    wait_ticks(20);
    rd(3'd1, v); chk(v, 8'h57, "R8 framing status, parity 0");
    wr(3'd2, 8'h40);
    @(negedge clk); chk(irq, 1, "R12 irq on summary error");
    rd(3'd4, v); chk(v, 8'h5A, "R8 byte stored");
    @(negedge clk); chk(irq, 0, "R12 irq cleared");
    wr(3'd2, 8'h00);
    drive_frame(8'h96, 1'b0);
    wait_ticks(20);
    rd(3'd1, v); chk(v, 8'h07, "R8 clean frame");
    rd(3'd4, v); chk(v, 8'h96, "R7 driven byte");

    // R11 pulse-width errors
    wait_ticks(1);
    @(negedge clk); drv_rx = 1'b1;
    @(negedge clk); drv_rx = 1'b0;
    wait_ticks(2);
    rd(3'd6, v); chk(v, 1, "R11 short pulse");
    wr(3'd5, 8'h01);
    rd(3'd6, v); chk(v, 0, "R11 cleared");
    wait_ticks(170); rd(3'd4, v);
    pulse_rx(10);
    wait_ticks(2);
    rd(3'd6, v); chk(v, 1, "R11 long pulse");
    wr(3'd5, 8'h01);
    wait_ticks(170); rd(3'd4, v);
    pulse_rx(5);
    wait_ticks(2);
    rd(3'd6, v); chk(v, 0, "R11 valid pulse");
    wait_ticks(170); rd(3'd4, v);

    summary();
  end
endmodule